// File: doc/BRIEF.md
# I2C Slave Register Port

This block is a slave on a two-wire serial bus. It gives an external bus master read and write access to an on-chip register space through 16-bit register addresses. Both bus lines are sampled on a fast system clock. Each line first passes a synchronizer and then a glitch filter, so spikes shorter than a set number of system clocks never reach the protocol logic. The block never drives the clock line. It pulls the data line low only through an open-drain enable, and only for acknowledge bits and for the zero bits of read data.

A write transfer starts with the device address byte carrying the write bit. Two register address bytes follow, high byte first, and then any number of data bytes. Each data byte produces one write strobe on the register side. A read transfer first sets the register address with a write phase. The master then sends a repeated start and the device address with the read bit, and the block returns bytes until the master answers one with a NACK. The register address steps by one after every byte written or fetched. The register side is a plain synchronous interface: an address, write data with a one-cycle write strobe, and a one-cycle read strobe. The read data must be valid one clock after the read strobe.

Top module: `i2c_regport`

## Requirements
- R1: After reset `sda_oe` is 0 and both strobes are 0. The block has no SCL output, and it asserts `sda_oe` only during its acknowledge bits and during the 0 bits of read data.
- R2: The device address is `1001` in bits 6..3 and the `strap_i` value in bits 2..0. `strap_i` is captured while `rst` is high and held after reset. When the 7-bit address matches, the block acknowledges by pulling SDA low in the ninth bit. On a mismatch it leaves SDA released and gives no strobes until the next start or stop.
- R3: After the device address with R/W bit (bit 0) = 0, the next two bytes set the register address, high byte first. Each following byte raises `reg_we` for one cycle, with `reg_wdata` holding the byte and `reg_addr` holding the target address. Every byte is acknowledged.
- R4: The register address increments by one after each byte written and after each byte fetched for reading. It wraps within 16 bits, and the carry propagates from the low byte into the high byte.
- R5: A pulse on SCL or SDA lasting fewer than `FILT_CYCLES` system clocks has no effect on the transfer.
- R6: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start in the middle of a byte restarts device address reception. A stop returns the block to idle with SDA released and no strobe for the partial byte.
- R7: A repeated start followed by the device address with R/W = 1 raises `reg_re` for one cycle. The block samples `reg_rdata` one cycle later and shifts the byte out MSB first.
- R8: When the master ACKs a read byte, the next byte is fetched. When the master NACKs, SDA stays released and no further `reg_re` occurs.
- R9: `sda_oe` changes only while SCL is low.
- R10: Transfers are correct at both 400 kHz and 100 kHz SCL.
- R11: `reg_we` and `reg_re` are never high together, and each is high for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (resolved bus value) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 3 | Low three device address bits, captured during reset |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid one cycle after `reg_re` |

## Verification
A wrong phase or bit count in the engine shows up within one byte time. The master sees an acknowledge in the wrong bit slot, or sees none at all, and a register strobe appears with an unexpected address or data. A faulty address counter shows up on the second byte of any burst, where the scoreboard compares `reg_addr` for each strobe. A filter that passes short pulses adds a false clock or a false start/stop within the same bit. That breaks the current byte, so the acknowledge and data checks fail right away.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int RA_W   = 16;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1001;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_SACK, PH_TX, PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    BY_DEV, BY_AHI, BY_ALO, BY_DATA
  } byte_t;
endpackage

// File: rtl/i2cp_filter.sv
module i2cp_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (sync_q[SYNC_STAGES-1] == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        filt_o <= sync_q[SYNC_STAGES-1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cp_cond.sv
module i2cp_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_evt = scl_f & scl_q & sda_q & ~sda_f;
    stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
  import i2cp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [RA_W-1:0]   reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  phase_t            phase;
  byte_t             kind;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] sh, rbuf;
  logic              rw, re_d1, ack_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  kind <= BY_DEV;  bitcnt <= '0;
      sh <= '0;  rbuf <= '0;  rw <= 1'b0;  re_d1 <= 1'b0;  ack_ok <= 1'b0;
      sda_oe <= 1'b0;  reg_addr <= '0;  reg_wdata <= '0;
      reg_we <= 1'b0;  reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      re_d1  <= reg_re;
      if (reg_we) reg_addr <= reg_addr + 1'b1;
      if (re_d1) begin
        rbuf     <= reg_rdata;
        reg_addr <= reg_addr + 1'b1;
      end
      if (stop_evt) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        phase  <= PH_RX;
        kind   <= BY_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise) begin
              sh     <= {sh[BYTE_W-2:0], sda_in};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                BY_DEV: begin
                  if (sh[7:1] == {DEV_PREFIX, strap_q}) begin
                    rw     <= sh[0];
                    reg_re <= sh[0];
                    kind   <= BY_AHI;
                    sda_oe <= 1'b1;
                    phase  <= PH_SACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BY_AHI: begin
                  reg_addr[RA_W-1:BYTE_W] <= sh;
                  kind <= BY_ALO;  sda_oe <= 1'b1;  phase <= PH_SACK;
                end
                BY_ALO: begin
                  reg_addr[BYTE_W-1:0] <= sh;
                  kind <= BY_DATA;  sda_oe <= 1'b1;  phase <= PH_SACK;
                end
                default: begin
                  reg_wdata <= sh;
                  reg_we    <= 1'b1;
                  sda_oe    <= 1'b1;
                  phase     <= PH_SACK;
                end
              endcase
            end
          end
          PH_SACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sh     <= rbuf;
                sda_oe <= ~rbuf[BYTE_W-1];
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                phase  <= PH_MACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_in;
              reg_re <= ~sda_in;
            end else if (scl_fall) begin
              if (ack_ok) begin
                sh     <= rbuf;
                sda_oe <= ~rbuf[BYTE_W-1];
                phase  <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2cp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  output logic [RA_W-1:0]   reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [2:0] strap_q;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cp_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .raw_i(raw_lines[g]), .filt_o(filt_lines[g]));
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  i2cp_cond u_cond (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2cp_engine u_eng (
    .clk(clk), .rst(rst), .strap_q(strap_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_in(sda_f),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_f,
  input logic        stop_evt,
  input logic        sda_oe,
  input logic        reg_we,
  input logic        reg_re,
  input logic [15:0] reg_addr
);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);
  assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));
  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  assert_re_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == $past(reg_addr) + 16'd1));
  assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .stop_evt(stop_evt),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr));

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus, sda_oe, reg_we, reg_re;
  logic [2:0]  strap = 3'b101;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [7:0]  mem [0:255];

  int total = 0, bad = 0, q = 157, we_cnt = 0, re_cnt = 0, r9_viol = 0;
  bit glitch = 1'b0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic [23:0] wq[$];
  logic [15:0] rq[$];

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regport u_i2c_regport (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      reg_rdata <= '0;
    end else begin
      if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
      if (reg_re) reg_rdata <= mem[reg_addr[7:0]];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe != prev_oe && scl_m) r9_viol++;
      prev_oe <= sda_oe;
      if (reg_we && reg_re) check(1'b0, "R11 dual strobe", 1, 0);
      if (reg_we) begin
        we_cnt++;
        if (wq.size() == 0) check(1'b0, "R3 unexpected write", int'(reg_addr), 0);
        else begin
          logic [23:0] e;
          e = wq.pop_front();
          check({reg_addr, reg_wdata} == e, "R3/R4 write addr+data",
                int'({reg_addr, reg_wdata}), int'(e));
        end
      end
      if (reg_re) begin
        re_cnt++;
        if (rq.size() == 0) check(1'b0, "R8 unexpected read strobe", int'(reg_addr), 0);
        else begin
          logic [15:0] e;
          e = rq.pop_front();
          check(reg_addr == e, "R7/R4 read addr", int'(reg_addr), int'(e));
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    if (glitch) begin
      wait_n(q / 2); scl_m = 1'b1; wait_n(10); scl_m = 1'b0; wait_n(q - q / 2 - 10);
    end else wait_n(q);
    sda_m = b; wait_n(q);
    scl_m = 1'b1;
    if (glitch) begin
      wait_n(q / 2); sda_m = ~b; wait_n(10); sda_m = b; wait_n(2 * q - q / 2 - 10);
    end else wait_n(2 * q);
    scl_m = 1'b0;
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wait_n(2 * q);
    scl_m = 1'b1; wait_n(q);
    b = sda_bus; wait_n(q);
    scl_m = 1'b0;
  endtask

  task automatic byte_w(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(a);
    acked = ~a;
  endtask

  task automatic byte_r(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(~give_ack);
  endtask

  task automatic do_start;
    sda_m = 1'b1; scl_m = 1'b1; wait_n(q);
    sda_m = 1'b0; wait_n(q);
    scl_m = 1'b0;
  endtask

  task automatic do_rstart;
    wait_n(q); sda_m = 1'b1; wait_n(q);
    scl_m = 1'b1; wait_n(q);
    sda_m = 1'b0; wait_n(q);
    scl_m = 1'b0;
  endtask

  task automatic do_stop;
    wait_n(q); sda_m = 1'b0; wait_n(q);
    scl_m = 1'b1; wait_n(q);
    sda_m = 1'b1; wait_n(q);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    wait_n(10);
    rst = 1'b0;
    strap = 3'b010;  // R2: live strap change must not matter
    wait_n(2);
    check(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    check(!reg_we && !reg_re, "R1 reset strobes", int'({reg_we, reg_re}), 0);

    // write burst across low-byte carry, with glitches injected (R3 R4 R5 R2)
    glitch = 1'b1;
    wq.push_back({16'h12FF, 8'hA5});
    wq.push_back({16'h1300, 8'h3C});
    do_start;
    byte_w(8'h9A, ack); check(ack, "R2 ack on strapped address", int'(ack), 1);
    byte_w(8'h12, ack); check(ack, "R3 ack high addr", int'(ack), 1);
    byte_w(8'hFF, ack); check(ack, "R3 ack low addr", int'(ack), 1);
    byte_w(8'hA5, ack); check(ack, "R5 ack data under glitches", int'(ack), 1);
    byte_w(8'h3C, ack); check(ack, "R4 ack second data", int'(ack), 1);
    do_stop;
    glitch = 1'b0;
    check(we_cnt == 2, "R5 write count with glitches", we_cnt, 2);

    // read burst via repeated start (R7 R8)
    rq.push_back(16'h12FF);
    rq.push_back(16'h1300);
    do_start;
    byte_w(8'h9A, ack);
    byte_w(8'h12, ack);
    byte_w(8'hFF, ack);
    do_rstart;
    byte_w(8'h9B, ack); check(ack, "R7 ack read address", int'(ack), 1);
    byte_r(1'b1, d); check(d == 8'hA5, "R7 read byte 1", int'(d), 8'hA5);
    byte_r(1'b0, d); check(d == 8'h3C, "R4 read byte 2", int'(d), 8'h3C);
    check(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
    do_stop;
    check(re_cnt == 2, "R8 no fetch after NACK", re_cnt, 2);

    // address mismatch (R2)
    do_start;
    byte_w(8'h94, ack); check(!ack, "R2 no ack on mismatch", int'(ack), 0);
    byte_w(8'h00, ack); check(!ack, "R2 silent until start", int'(ack), 0);
    do_stop;
    check(we_cnt == 2 && re_cnt == 2, "R2 no strobes on mismatch", we_cnt + re_cnt, 4);

    // start mid-byte restarts address reception (R6)
    wq.push_back({16'h0040, 8'h77});
    do_start;
    byte_w(8'h9A, ack);
    for (int i = 0; i < 4; i++) bit_w(1'b1);
    do_rstart;
    byte_w(8'h9A, ack); check(ack, "R6 ack after mid-byte start", int'(ack), 1);
    byte_w(8'h00, ack);
    byte_w(8'h40, ack);
    byte_w(8'h77, ack); check(ack, "R6 data after restart", int'(ack), 1);
    do_stop;

    // stop mid-byte aborts (R6)
    do_start;
    byte_w(8'h9A, ack);
    for (int i = 0; i < 3; i++) bit_w(1'b0);
    do_stop;
    wait_n(40);
    check(sda_oe == 1'b0, "R6 released after stop", int'(sda_oe), 0);
    check(we_cnt == 3, "R6 no write from partial byte", we_cnt, 3);

    // standard-rate read at current address (R10)
    q = 625;
    rq.push_back(16'h0041);
    do_start;
    byte_w(8'h9B, ack); check(ack, "R10 ack at 100 kHz", int'(ack), 1);
    byte_r(1'b0, d);
    check(d == (8'h41 ^ 8'h5A), "R10 read at 100 kHz", int'(d), int'(8'h41 ^ 8'h5A));
    do_stop;
    wait_n(20);

    check(wq.size() == 0 && rq.size() == 0, "R3 scoreboard drained",
          wq.size() + rq.size(), 0);
    check(r9_viol == 0, "R9 sda_oe changed with SCL high", r9_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule